// File: doc/BRIEF.md
# Divided-Clock Start Synchronizer

This block starts output on several waveform-generator channels at the same moment. Each channel runs on its own fast sample clock. The block divides that clock by a programmable integer ratio to make a slow trigger clock, so that the trigger clock period is long compared with the delay on the board. One channel is the master. Once armed, it raises a shared trigger line at a falling edge of its slow clock. Every channel samples the line at the next rising edge of its slow clock, the master included. A channel that finds the line high while armed issues a one-cycle start strobe in the sample-clock domain. The half period between the launch edge and the capture edge covers the time the line takes to reach every device.

To line up the slow clocks of all channels, each channel takes an alignment tick derived from a shared reference. When that tick arrives, the divider count is loaded with a per-channel offset in whole sample clocks. After the divider phase has been aligned, a channel is armed with a single pulse. A channel accepts one trigger per arm.

Top module: `trig_align_top`

## Requirements
- R1: The ratio in use is the 9-bit `div_ratio_i` clamped to the range 2 to 256: values 0 and 1 act as 2, and values above 256 act as 256. The slow clock period equals that ratio in sample clocks. The slow clock is high for floor(ratio/2) cycles and low for the remaining cycles.
- R2: A new ratio is taken up only while the channel is idle, which means not armed and not driving the trigger line. While armed, the slow clock keeps its old period.
- R3: An alignment tick while idle loads the divider count with `phase_ofs_i`, limited to ratio−1. For an offset O with 1 ≤ O < ratio, the next rising slow-clock edge comes O sample edges before the end of the period, that is ratio−O sample edges after the load edge. A larger offset acts as ratio−1 and gives one edge.
- R4: An armed master raises `trig_o` on the same sample edge at which the slow clock falls. It holds `trig_o` for exactly ratio sample cycles and lowers it together with the next slow-clock fall. It launches at most once per arm.
- R5: A channel with `master_en_i` low never drives `trig_o`.
- R6: If `trig_line_i` is high at the sample edge where the slow clock rises and the channel is armed, `start_o` is high for exactly one cycle. That cycle is the first high cycle of the slow clock, ratio−floor(ratio/2) cycles after the launching fall.
- R7: A trigger line that is high while the channel is not armed gives no start.
- R8: A start disarms the channel. Later trigger pulses give no start until `arm_i` is pulsed again.
- R9: Reset low clears the divider, the armed state and the outputs: `slow_clk_o`, `trig_o` and `start_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| div_ratio_i | input | 9 | Requested divide ratio, clamped to 2..256 |
| phase_ofs_i | input | 8 | Divider phase offset in sample clocks |
| ref_tick_i | input | 1 | Alignment tick from the shared reference, already in the sample-clock domain |
| master_en_i | input | 1 | Channel acts as trigger master |
| arm_i | input | 1 | Arm request pulse, accepted while idle |
| trig_line_i | input | 1 | Shared trigger line as received |
| trig_o | output | 1 | Drive for the shared trigger line (master only) |
| slow_clk_o | output | 1 | Divided trigger clock |
| start_o | output | 1 | One-cycle start-generation strobe |

## Verification
The properties assume three things. First, `master_en_i` does not change while a trigger is being driven. Second, the received line comes from a master whose slow clock is in phase with this channel's slow clock. Third, the alignment tick and the arm pulse come as single-cycle pulses. The stimulus meets these assumptions in four ways. It changes the ratio, the offset and the master selection only while the channel is idle. It loops the channel's own drive back to the line when the channel is master. When the channel is not master, it plays the remote master by raising the line at an observed slow-clock fall for exactly one slow period. It drives all inputs on falling sample-clock edges.

// File: rtl/trig_align_pkg.sv
package trig_align_pkg;
  localparam int RATIO_W   = 9;
  localparam int MIN_RATIO = 2;
  localparam int MAX_RATIO = 256;
endpackage

// File: rtl/trig_align_div.sv
module trig_align_div #(
  parameter int RATIO_W   = 9,
  parameter int OFS_W     = RATIO_W - 1,
  parameter int MIN_RATIO = 2,
  parameter int MAX_RATIO = 256
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               idle_i,
  input  logic [RATIO_W-1:0] ratio_i,
  input  logic [OFS_W-1:0]   ofs_i,
  input  logic               ref_tick_i,
  output logic               slow_o,
  output logic               rise_o,
  output logic               fall_o
);
  localparam logic [RATIO_W-1:0] RMIN = RATIO_W'(MIN_RATIO);
  localparam logic [RATIO_W-1:0] RMAX = RATIO_W'(MAX_RATIO);

  logic [RATIO_W-1:0] ratio_q, ratio_c, half, last, ofs_c, cnt_q, cnt_nxt;
  logic               slow_q, slow_nxt;

  always_comb begin
    if (ratio_i < RMIN)      ratio_c = RMIN;
    else if (ratio_i > RMAX) ratio_c = RMAX;
    else                     ratio_c = ratio_i;
    half  = ratio_q >> 1;
    last  = ratio_q - 1'b1;
    ofs_c = ({1'b0, ofs_i} > last) ? last : {1'b0, ofs_i};
    if (idle_i && ref_tick_i) cnt_nxt = ofs_c;
    else if (cnt_q >= last)   cnt_nxt = '0;
    else                      cnt_nxt = cnt_q + 1'b1;
    slow_nxt = cnt_nxt < half;
  end

  // edge events refer to the coming clock edge
  assign rise_o = !slow_q && slow_nxt;
  assign fall_o = slow_q && !slow_nxt;
  assign slow_o = slow_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      slow_q  <= 1'b0;
      ratio_q <= RMIN;
    end else begin
      cnt_q  <= cnt_nxt;
      slow_q <= slow_nxt;
      if (idle_i) ratio_q <= ratio_c;
    end
  end
endmodule

// File: rtl/trig_align_ctrl.sv
module trig_align_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic master_en_i,
  input  logic arm_i,
  input  logic trig_line_i,
  input  logic rise_i,
  input  logic fall_i,
  output logic idle_o,
  output logic trig_o,
  output logic start_o
);
  logic armed_q, launched_q, trig_q, start_q;

  assign idle_o  = !armed_q && !trig_q;
  assign trig_o  = trig_q;
  assign start_o = start_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q    <= 1'b0;
      launched_q <= 1'b0;
      trig_q     <= 1'b0;
      start_q    <= 1'b0;
    end else begin
      start_q <= 1'b0;
      if (idle_o && arm_i) begin
        armed_q    <= 1'b1;
        launched_q <= 1'b0;
      end
      if (fall_i) begin
        if (trig_q) trig_q <= 1'b0;
        else if (armed_q && master_en_i && !launched_q) begin
          trig_q     <= 1'b1;
          launched_q <= 1'b1;
        end
      end
      if (rise_i && armed_q && trig_line_i) begin
        start_q <= 1'b1;
        armed_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/trig_align_top.sv
module trig_align_top
  import trig_align_pkg::*;
#(
  parameter int R_W   = RATIO_W,
  parameter int O_W   = R_W - 1,
  parameter int R_MIN = MIN_RATIO,
  parameter int R_MAX = MAX_RATIO
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [R_W-1:0] div_ratio_i,
  input  logic [O_W-1:0] phase_ofs_i,
  input  logic           ref_tick_i,
  input  logic           master_en_i,
  input  logic           arm_i,
  input  logic           trig_line_i,
  output logic           trig_o,
  output logic           slow_clk_o,
  output logic           start_o
);
  logic idle, rise, fall;

  trig_align_div #(
    .RATIO_W(R_W), .OFS_W(O_W), .MIN_RATIO(R_MIN), .MAX_RATIO(R_MAX)
  ) u_div (
    .clk_i(clk_i), .rst_ni(rst_ni), .idle_i(idle), .ratio_i(div_ratio_i),
    .ofs_i(phase_ofs_i), .ref_tick_i(ref_tick_i), .slow_o(slow_clk_o),
    .rise_o(rise), .fall_o(fall)
  );

  trig_align_ctrl u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .master_en_i(master_en_i), .arm_i(arm_i),
    .trig_line_i(trig_line_i), .rise_i(rise), .fall_i(fall), .idle_o(idle),
    .trig_o(trig_o), .start_o(start_o)
  );
endmodule

// File: rtl/trig_align_chk.sv
module trig_align_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic master_en_i,
  input logic trig_line_i,
  input logic trig_o,
  input logic slow_clk_o,
  input logic start_o
);
  p_launch_on_fall_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(trig_o) |-> $fell(slow_clk_o));
  p_release_on_fall_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(trig_o) |-> $fell(slow_clk_o));
  p_master_only_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(trig_o) |-> master_en_i);
  p_start_on_rise_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> $rose(slow_clk_o));
  p_start_needs_line_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> $past(trig_line_i));
  p_start_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o);
endmodule

bind trig_align_top trig_align_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .master_en_i(master_en_i),
  .trig_line_i(trig_line_i), .trig_o(trig_o), .slow_clk_o(slow_clk_o),
  .start_o(start_o)
);

// File: tb/sim_trig_align_top.sv
`timescale 1ns/1ps
module sim_trig_align_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [8:0] div_ratio_i = 9'd4;
  logic [7:0] phase_ofs_i = '0;
  logic       ref_tick_i = 1'b0, master_en_i = 1'b0, arm_i = 1'b0, ext_line = 1'b0;
  logic       trig_line_i, trig_o, slow_clk_o, start_o;
  logic       s_prev = 1'b0, t_prev = 1'b0;
  int         checks = 0, errors = 0;
  bit         done = 1'b0;

  assign trig_line_i = master_en_i ? trig_o : ext_line;

  trig_align_top u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .div_ratio_i(div_ratio_i),
    .phase_ofs_i(phase_ofs_i), .ref_tick_i(ref_tick_i), .master_en_i(master_en_i),
    .arm_i(arm_i), .trig_line_i(trig_line_i), .trig_o(trig_o),
    .slow_clk_o(slow_clk_o), .start_o(start_o)
  );

  always #2 clk_i = ~clk_i;

  // ratio, offset, master, expected edges from load to first rise
  localparam int NV = 7;
  localparam int VEC [NV][4] = '{
    '{2, 1, 1, 1}, '{3, 1, 1, 2}, '{8, 3, 1, 5}, '{10, 7, 0, 3},
    '{5, 2, 0, 3}, '{16, 15, 1, 1}, '{7, 20, 1, 1}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    s_prev = slow_clk_o;
    t_prev = trig_o;
    @(negedge clk_i);
  endtask

  task automatic wait_rise();
    for (int i = 0; i < 1000; i++) begin
      tick();
      if (!s_prev && slow_clk_o) break;
    end
  endtask

  task automatic wait_fall();
    for (int i = 0; i < 1000; i++) begin
      tick();
      if (s_prev && !slow_clk_o) break;
    end
  endtask

  task automatic measure(output int hi, output int lo);
    wait_rise();
    hi = 1;
    for (int i = 0; i < 1000; i++) begin
      tick();
      if (!slow_clk_o) break;
      hi++;
    end
    lo = 1;
    for (int i = 0; i < 1000; i++) begin
      tick();
      if (slow_clk_o) break;
      lo++;
    end
  endtask

  task automatic arm_pulse();
    arm_i = 1'b1;
    tick();
    arm_i = 1'b0;
  endtask

  // arms, runs one trigger cycle and checks launch width and start placement
  task automatic run_start(input int r, input bit m);
    int w, n, ns, h;
    h = r / 2;
    arm_pulse();
    if (m) begin
      for (int i = 0; i < 2000; i++) begin
        tick();
        if (!t_prev && trig_o) break;
      end
      chk(s_prev && !slow_clk_o, "R4 launch at slow fall", slow_clk_o, 0);
    end else begin
      wait_fall();
      ext_line = 1'b1;
    end
    w = 1; n = 0; ns = 0;
    for (int k = 1; k <= r + 2; k++) begin
      tick();
      if (!m && k == r) ext_line = 1'b0;
      if (m && trig_o) w++;
      if (!m) chk(!trig_o, "R5 non-master drive", trig_o, 0);
      if (start_o) begin
        ns++;
        n = k;
        chk(!s_prev && slow_clk_o, "R6 start in first high cycle", slow_clk_o, 1);
      end
    end
    if (m) chk(w == r, "R4 trigger width", w, r);
    chk(ns == 1, "R6 single start", ns, 1);
    chk(n == r - h, "R6 start latency", n, r - h);
  endtask

  initial begin
    int hi, lo, d, r, ns;
    repeat (3) tick();
    chk(!slow_clk_o && !trig_o && !start_o, "R9 reset outputs", {slow_clk_o, trig_o, start_o}, 0);
    rst_ni = 1'b1;
    repeat (3) tick();

    for (int v = 0; v < NV; v++) begin
      r = VEC[v][0];
      div_ratio_i = 9'(r);
      phase_ofs_i = 8'(VEC[v][1]);
      master_en_i = VEC[v][2][0];
      repeat (3) tick();
      ref_tick_i = 1'b1;
      tick();
      ref_tick_i = 1'b0;
      d = 0;
      for (int k = 1; k < 1000; k++) begin
        tick();
        if (!s_prev && slow_clk_o) begin d = k; break; end
      end
      chk(d == VEC[v][3], "R3 phase load", d, VEC[v][3]);
      run_start(r, VEC[v][2][0]);
      measure(hi, lo);
      chk(hi == r / 2 && lo == r - r / 2, "R1 slow clock shape", hi * 1000 + lo, (r / 2) * 1000 + r - r / 2);
    end

    // R1 clamping at both ends
    master_en_i = 1'b0;
    div_ratio_i = 9'd1;
    repeat (3) tick();
    measure(hi, lo);
    chk(hi + lo == 2, "R1 low clamp", hi + lo, 2);
    div_ratio_i = 9'd300;
    repeat (3) tick();
    measure(hi, lo);
    chk(hi == 128 && lo == 128, "R1 high clamp", hi + lo, 256);

    // R7 trigger while idle ignored
    div_ratio_i = 9'd6;
    repeat (3) tick();
    ns = 0;
    ext_line = 1'b1;
    for (int k = 0; k < 20; k++) begin tick(); if (start_o) ns++; end
    ext_line = 1'b0;
    chk(ns == 0, "R7 unarmed trigger", ns, 0);

    // R8 no second start without re-arm
    run_start(6, 1'b0);
    ns = 0;
    ext_line = 1'b1;
    for (int k = 0; k < 14; k++) begin tick(); if (start_o) ns++; end
    ext_line = 1'b0;
    chk(ns == 0, "R8 start without re-arm", ns, 0);

    // R2 ratio held while armed
    arm_pulse();
    div_ratio_i = 9'd12;
    repeat (2) tick();
    measure(hi, lo);
    chk(hi + lo == 6, "R2 ratio held while armed", hi + lo, 6);
    wait_fall();
    ext_line = 1'b1;
    ns = 0;
    for (int k = 0; k < 6; k++) begin tick(); if (start_o) ns++; end
    ext_line = 1'b0;
    chk(ns == 1, "R2 start before ratio change", ns, 1);
    repeat (3) tick();
    measure(hi, lo);
    chk(hi + lo == 12, "R2 ratio taken when idle", hi + lo, 12);

    // R9 reset during an active trigger
    master_en_i = 1'b1;
    div_ratio_i = 9'd8;
    repeat (3) tick();
    arm_pulse();
    for (int i = 0; i < 100; i++) begin tick(); if (trig_o) break; end
    chk(trig_o, "R9 trigger active before reset", trig_o, 1);
    rst_ni = 1'b0;
    #1;
    chk(!trig_o && !start_o && !slow_clk_o, "R9 async clear", {slow_clk_o, trig_o, start_o}, 0);
    tick();
    rst_ni = 1'b1;
    ns = 0;
    for (int k = 0; k < 32; k++) begin tick(); if (trig_o || start_o) ns++; end
    chk(ns == 0, "R9 disarmed after reset", ns, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule